// File: doc/BRIEF.md
# SPDIF Channel-Status Capture Buffer

This block gathers the channel-status bit carried by every subframe of an SPDIF stream, keeping a separate 192-bit record for channel A and channel B. Bits land in a working store as they arrive. Once both channels have delivered a complete block, the whole working store is copied into a holding store in a single cycle. The host reads only the holding store, so the host always sees a complete block and the stream can keep arriving underneath.

The host sees the holding store as 24 byte registers per channel. A select bit in a control register chooses which channel those registers show. A sticky interrupt flag reports completed blocks. The flag can fire on every block. It can instead fire only when the status content has changed, and that comparison can be narrowed to the leading five bytes.

Upstream logic (biphase decoding and preamble detection) supplies one strobe per subframe. With each strobe it gives the status bit, the channel, and a marker that flags the first frame of a block.

Top module: `spdif_cs_capture`

## Requirements
- R1: After reset both stores are all zero, the flag is clear, the control register reads 0x00 (channel A selected, flag on every block, full compare), and `irq_o` is low.
- R2: Within a channel, the n-th status bit since the last block-start marker is stored at byte n/8, bit n%8. Bit 0 of each byte is the earliest received bit. A subframe that carries the marker is stored at bit position 0.
- R3: The holding store changes only in the cycle after both channels have delivered bit 191. It is loaded one clock after the strobe that completes the second channel. A partial block never alters it.
- R4: A read strobe at address 0x20+k (k = 0..23) returns byte k of the selected channel's holding store on `rd_data_o` one clock later. `rd_data_o` holds its value while no read is strobed.
- R5: The control register is at address 0x10. Its bit 0 selects the channel shown at 0x20..0x37: 0 for channel A, 1 for channel B. The whole register reads back as written.
- R6: When control bit 1 is 0, every block copy sets the flag.
- R7: When control bit 1 is 1, a block copy sets the flag only if some compared byte of either channel in the new block differs from the holding store it replaces.
- R8: When control bit 2 is 1, the comparison covers bytes 0..4 only. A difference confined to bytes 5..23 does not set the flag.
- R9: The flag reads as bit 0 of address 0x11 and drives `irq_o`. It stays set until a write to 0x11 with data bit 0 set. A write with bit 0 clear has no effect. If a set event falls in the same cycle as a clear, the flag stays set.
- R10: A read strobed in the same cycle as the block copy returns the previous block's byte.
- R11: Subframes arriving after a channel has stored 192 bits, with no block-start marker, are dropped and leave that channel's stored bits unchanged.
- R12: A read at any address other than 0x10, 0x11 or 0x20..0x37 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sf_valid_i | input | 1 | One-cycle strobe per received subframe |
| sf_chan_b_i | input | 1 | Subframe channel: 0 = A, 1 = B |
| sf_start_i | input | 1 | Subframe belongs to the first frame of a block |
| sf_cs_bit_i | input | 1 | Channel-status bit of the subframe |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 8 | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 8 | Host read address |
| rd_data_o | output | 8 | Read data, valid one clock after the strobe |
| irq_o | output | 1 | Sticky status-block flag |

## Verification
The bench sends complete blocks whose bit pattern differs by channel and by seed, so that byte order, in-byte bit order and channel mixing can all be told apart. It sends one block that repeats the held content, one with a single inverted byte beyond the first five, and one with an inverted byte inside the first five. These three separate the every-block, change-only and head-only flag modes. A truncated block shows that incomplete data never reaches the holding store, and a block padded with surplus channel-A bits shows that overflow is dropped. A read and a flag clear placed exactly on the copy cycle check the read ordering and the priority of set over clear.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;
  localparam int unsigned CS_BITS_DEF   = 192;
  localparam int unsigned BYTE_W_DEF    = 8;
  localparam int unsigned CMP_BYTES_DEF = 5;

  // control register field layout, bit 0 is the channel select
  typedef struct packed {
    logic head_only;
    logic chg_mode;
    logic sel_b;
  } ctrl_f_t;
endpackage

// File: rtl/spdif_cs_lane.sv
module spdif_cs_lane #(
  parameter int unsigned CS_BITS = 192
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sf_valid_i,
  input  logic               sf_start_i,
  input  logic               sf_bit_i,
  input  logic               ack_i,
  output logic [CS_BITS-1:0] work_o,
  output logic               done_o
);
  localparam int unsigned IDX_W = $clog2(CS_BITS + 1);

  logic [IDX_W-1:0]   idx_q, pos;
  logic [CS_BITS-1:0] work_q;
  logic               done_q, wr_ok;

  assign pos   = sf_start_i ? '0 : idx_q;
  assign wr_ok = sf_valid_i && (pos < IDX_W'(CS_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      work_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        work_q[pos] <= sf_bit_i;
        idx_q       <= pos + 1'b1;
      end
      // completion wins over acknowledge
      if (wr_ok && pos == IDX_W'(CS_BITS - 1))
        done_q <= 1'b1;
      else if (ack_i || (sf_valid_i && sf_start_i))
        done_q <= 1'b0;
    end
  end

  assign work_o = work_q;
  assign done_o = done_q;

  p_idx_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(CS_BITS));

  p_drop_over_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_valid_i && !sf_start_i && idx_q == IDX_W'(CS_BITS)) |=> $stable(work_q));

  p_start_pos_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_valid_i && sf_start_i) |=> (idx_q == IDX_W'(1) && work_q[0] == $past(sf_bit_i)));
endmodule

// File: rtl/spdif_cs_hold.sv
module spdif_cs_hold #(
  parameter int unsigned CS_BITS   = 192,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned CMP_BYTES = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               copy_i,
  input  logic               head_only_i,
  input  logic [CS_BITS-1:0] work_a_i,
  input  logic [CS_BITS-1:0] work_b_i,
  output logic [CS_BITS-1:0] hold_a_o,
  output logic [CS_BITS-1:0] hold_b_o,
  output logic               diff_o
);
  localparam int unsigned NUM_BYTES = CS_BITS / BYTE_W;

  logic [CS_BITS-1:0]   hold_a_q, hold_b_q;
  logic [NUM_BYTES-1:0] byte_diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_a_q <= '0;
      hold_b_q <= '0;
    end else if (copy_i) begin
      hold_a_q <= work_a_i;
      hold_b_q <= work_b_i;
    end
  end

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_cmp
    localparam bit IN_HEAD = (k < CMP_BYTES);
    logic a_ne, b_ne;
    assign a_ne = work_a_i[k*BYTE_W +: BYTE_W] != hold_a_q[k*BYTE_W +: BYTE_W];
    assign b_ne = work_b_i[k*BYTE_W +: BYTE_W] != hold_b_q[k*BYTE_W +: BYTE_W];
    assign byte_diff[k] = (a_ne || b_ne) && (IN_HEAD || !head_only_i);
  end

  assign diff_o   = |byte_diff;
  assign hold_a_o = hold_a_q;
  assign hold_b_o = hold_b_q;

  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !copy_i |=> ($stable(hold_a_q) && $stable(hold_b_q)));

  p_hold_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_i |=> (hold_a_q == $past(work_a_i) && hold_b_q == $past(work_b_i)));
endmodule

// File: rtl/spdif_cs_flag.sv
module spdif_cs_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/spdif_cs_capture.sv
module spdif_cs_capture
  import spdif_cs_pkg::*;
#(
  parameter int unsigned       CS_BITS   = CS_BITS_DEF,
  parameter int unsigned       BYTE_W    = BYTE_W_DEF,
  parameter int unsigned       CMP_BYTES = CMP_BYTES_DEF,
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CS_BASE   = 'h20,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sf_valid_i,
  input  logic              sf_chan_b_i,
  input  logic              sf_start_i,
  input  logic              sf_cs_bit_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned NUM_BYTES = CS_BITS / BYTE_W;

  logic [CS_BITS-1:0] work [2];
  logic [1:0]         done;
  logic               copy, diff, flag, flag_set, flag_clr, rd_hit;
  logic [CS_BITS-1:0] hold_a, hold_b;
  logic [BYTE_W-1:0]  ctrl_q, rd_q, rd_next;
  ctrl_f_t            cf;

  assign cf   = ctrl_f_t'(ctrl_q[2:0]);
  assign copy = &done;

  for (genvar c = 0; c < 2; c++) begin : g_lane
    logic lane_v;
    assign lane_v = sf_valid_i && (sf_chan_b_i == 1'(c));
    spdif_cs_lane #(.CS_BITS(CS_BITS)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sf_valid_i (lane_v),
      .sf_start_i (sf_start_i),
      .sf_bit_i   (sf_cs_bit_i),
      .ack_i      (copy),
      .work_o     (work[c]),
      .done_o     (done[c])
    );
  end

  spdif_cs_hold #(
    .CS_BITS   (CS_BITS),
    .BYTE_W    (BYTE_W),
    .CMP_BYTES (CMP_BYTES)
  ) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .copy_i      (copy),
    .head_only_i (cf.head_only),
    .work_a_i    (work[0]),
    .work_b_i    (work[1]),
    .hold_a_o    (hold_a),
    .hold_b_o    (hold_b),
    .diff_o      (diff)
  );

  assign flag_set = copy && (!cf.chg_mode || diff);
  assign flag_clr = wr_en_i && (wr_addr_i == FLAG_ADDR) && wr_data_i[0];

  spdif_cs_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == CTRL_ADDR) ctrl_q <= wr_data_i;
  end

  always_comb begin
    rd_next = '0;
    rd_hit  = 1'b0;
    if (rd_addr_i == CTRL_ADDR) begin
      rd_next = ctrl_q;
      rd_hit  = 1'b1;
    end
    if (rd_addr_i == FLAG_ADDR) begin
      rd_next = BYTE_W'(flag);
      rd_hit  = 1'b1;
    end
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (rd_addr_i == ADDR_W'(CS_BASE + k)) begin
        rd_next = cf.sel_b ? hold_b[k*BYTE_W +: BYTE_W] : hold_a[k*BYTE_W +: BYTE_W];
        rd_hit  = 1'b1;
      end
    end
  end

  // read data sampled before the copy edge lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_next;
  end

  assign rd_data_o = rd_q;
  assign irq_o     = flag;

  p_unmapped_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_hit) |=> rd_data_o == '0);

  p_every_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy && !cf.chg_mode) |=> irq_o);

  p_no_change_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy && cf.chg_mode && !diff && !flag) |=> !irq_o);

  p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/spdif_cs_capture_tb.sv
module spdif_cs_capture_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sf_valid = 0, sf_chan_b = 0, sf_start = 0, sf_bit = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit started = 0, finished = 0;

  always #4 clk = ~clk;

  spdif_cs_capture u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sf_valid_i(sf_valid), .sf_chan_b_i(sf_chan_b), .sf_start_i(sf_start), .sf_cs_bit_i(sf_bit),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  // behavioural reference model
  logic [191:0] m_work [2];
  logic [191:0] m_hold [2];
  int           m_idx  [2];
  bit           m_done [2];
  bit           m_flag;
  logic [7:0]   m_ctrl, m_rd;
  bit           cp, ev, df;
  int           p, c;

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a == 8'h10) return m_ctrl;
    if (a == 8'h11) return {7'b0, m_flag};
    if (a >= 8'h20 && a <= 8'h37) return m_hold[m_ctrl[0]][(a - 8'h20)*8 +: 8];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_work[i] = '0; m_hold[i] = '0; m_idx[i] = 0; m_done[i] = 0;
      end
      m_flag = 0; m_ctrl = 0; m_rd = 0;
    end else begin
      cp = m_done[0] && m_done[1];
      ev = 0; df = 0;
      if (rd_en) m_rd = model_read(rd_addr);
      if (cp) begin
        for (int k = 0; k < 24; k++)
          if (!m_ctrl[2] || k < 5)
            for (int h = 0; h < 2; h++)
              if (m_work[h][k*8 +: 8] != m_hold[h][k*8 +: 8]) df = 1;
        ev = m_ctrl[1] ? df : 1'b1;
        m_hold[0] = m_work[0]; m_hold[1] = m_work[1];
        m_done[0] = 0; m_done[1] = 0;
      end
      if (wr_en && wr_addr == 8'h10) m_ctrl = wr_data;
      if (wr_en && wr_addr == 8'h11 && wr_data[0]) m_flag = 0;
      if (ev) m_flag = 1;
      if (sf_valid) begin
        c = sf_chan_b ? 1 : 0;
        if (sf_start) begin p = 0; m_done[c] = 0; end else p = m_idx[c];
        if (p < 192) begin
          m_work[c][p] = sf_bit;
          m_idx[c] = p + 1;
          if (p == 191) m_done[c] = 1;
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && started && !finished) begin
      n_chk++;
      if (irq !== m_flag) begin
        n_fail++;
        $display("FAIL R9 model irq: actual %0b expected %0b", irq, m_flag);
      end
      n_chk++;
      if (rd_data !== m_rd) begin
        n_fail++;
        $display("FAIL R4 model rd_data: actual %h expected %h", rd_data, m_rd);
      end
    end
  end

  // independent expected values
  function automatic bit pat(input int seed, input int ch, input int j, input int flip);
    bit b;
    b = (seed == 0) ? 1'b0 : (((j*7 + seed*13 + ch*5) % 3) == 0);
    if (ch == 0 && (j / 8) == flip) b = ~b;
    return b;
  endfunction

  function automatic logic [7:0] exp_byte(input int seed, input int ch, input int k, input int flip);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = pat(seed, ch, k*8 + i, flip);
    return v;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sf(input bit b, input bit chb, input bit st);
    sf_valid = 1; sf_bit = b; sf_chan_b = chb; sf_start = st;
    @(negedge clk);
    sf_valid = 0; sf_start = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // action: 0 none, 1 read 0x20 on the copy cycle, 2 flag clear on the copy cycle
  task automatic send_block(input int seed, input int flip, input int action, input bit extra);
    for (int j = 0; j < 192; j++) begin
      sf(pat(seed, 0, j, flip), 1'b0, j == 0);
      if (j == 191 && extra) repeat (8) sf(1'b1, 1'b0, 1'b0);
      sf(pat(seed, 1, j, flip), 1'b1, j == 0);
    end
    if (action == 1) rd(8'h20);
    else if (action == 2) wr(8'h11, 8'h01);
    idle(2);
  endtask

  task automatic send_partial(input int seed, input int n);
    for (int j = 0; j < n; j++) begin
      sf(pat(seed, 0, j, -1), 1'b0, j == 0);
      sf(pat(seed, 1, j, -1), 1'b1, j == 0);
    end
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    started = 1;
    idle(2);

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd(8'h20); check("R1 hold byte0", rd_data, 8'h00);
    rd(8'h37); check("R1 hold byte23", rd_data, 8'h00);
    rd(8'h10); check("R1 ctrl", rd_data, 8'h00);
    rd(8'h11); check("R1 flag", rd_data, 8'h00);

    // R6 every block, R2/R4 layout, R5 select
    send_block(1, -1, 0, 0);
    check("R6 flag after block", {7'b0, irq}, 8'h01);
    rd(8'h20); check("R4 A byte0", rd_data, exp_byte(1, 0, 0, -1));
    rd(8'h21); check("R2 A byte1 bit order", rd_data, exp_byte(1, 0, 1, -1));
    rd(8'h37); check("R4 A byte23", rd_data, exp_byte(1, 0, 23, -1));
    wr(8'h10, 8'hA1);
    rd(8'h10); check("R5 ctrl readback", rd_data, 8'hA1);
    rd(8'h20); check("R5 B byte0", rd_data, exp_byte(1, 1, 0, -1));
    rd(8'h2C); check("R5 B byte12", rd_data, exp_byte(1, 1, 12, -1));
    rd(8'h05); check("R12 low unmapped", rd_data, 8'h00);
    rd(8'h38); check("R12 past end", rd_data, 8'h00);
    rd(8'h1F); check("R12 below base", rd_data, 8'h00);

    // R9 clear behaviour
    wr(8'h11, 8'h00);
    check("R9 write0 keeps flag", {7'b0, irq}, 8'h01);
    rd(8'h11); check("R9 flag readback", rd_data, 8'h01);
    wr(8'h11, 8'h01);
    check("R9 write1 clears", {7'b0, irq}, 8'h00);

    // R7 change-only mode
    wr(8'h10, 8'h02);
    send_block(1, -1, 0, 0);
    check("R7 identical block no flag", {7'b0, irq}, 8'h00);
    send_block(1, 10, 0, 0);
    check("R7 byte10 change flags", {7'b0, irq}, 8'h01);
    wr(8'h11, 8'h01);

    // R8 head-only comparison
    wr(8'h10, 8'h06);
    send_block(1, -1, 0, 0);
    check("R8 byte10 change ignored", {7'b0, irq}, 8'h00);
    send_block(1, 2, 0, 0);
    check("R8 byte2 change flags", {7'b0, irq}, 8'h01);
    wr(8'h11, 8'h01);

    // R3 partial block leaves holding store alone
    send_partial(9, 100);
    check("R3 no flag on partial", {7'b0, irq}, 8'h00);
    rd(8'h22); check("R3 hold byte2 kept", rd_data, exp_byte(1, 0, 2, 2));

    // R10 read on the copy cycle returns old block
    wr(8'h10, 8'h00);
    send_block(2, -1, 1, 0);
    check("R10 read at copy", rd_data, exp_byte(1, 0, 0, 2));
    rd(8'h20); check("R3 new block visible", rd_data, exp_byte(2, 0, 0, -1));
    check("R6 flag on new block", {7'b0, irq}, 8'h01);

    // R11 surplus channel-A bits dropped
    wr(8'h11, 8'h01);
    send_block(0, -1, 0, 1);
    check("R11 flag", {7'b0, irq}, 8'h01);
    rd(8'h37); check("R11 A byte23", rd_data, 8'h00);
    rd(8'h20); check("R11 A byte0", rd_data, 8'h00);

    // R9 set wins over simultaneous clear
    wr(8'h11, 8'h01);
    check("R9 cleared before", {7'b0, irq}, 8'h00);
    send_block(4, -1, 2, 0);
    check("R9 set beats clear", {7'b0, irq}, 8'h01);
    wr(8'h11, 8'h01);
    check("R9 final clear", {7'b0, irq}, 8'h00);
    rd(8'h21); check("R2 A byte1 seed4", rd_data, exp_byte(4, 0, 1, -1));

    idle(2);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule